// File: doc/BRIEF.md
# Calendar Counter Snapshot Bank

This block keeps a byte-wide shadow copy of the calendar counters, so that a host can read a time value that came from a single clock edge. A save-enable control bit sets the mode. While the bit is high, the bank copies the live counter bytes on every cycle. When the bit goes low, the bank keeps the copy taken on the last tracking cycle, and the host reads that frozen time at any pace without tearing across a roll-over. While the bit is low and no snapshot is needed, the bank works as a small general-purpose read/write memory.

A row of sticky roll-over flags, one for each of the fastest counters, supports the other way to read the time: reading the counters directly. A counter's increment pulse sets its flag, and a read of the flags clears them. The host clears the flag, reads the counter bytes, and reads the flag again. A set flag means the reading may be torn and must be repeated.

Top module: `tsb_snapshot_bank`

## Requirements
- R1: After a synchronous reset, `save_en` is 0, every roll-over flag is 0 and every bank byte reads 0.
- R2: A control write loads `save_en` from bit 7 of `ctrl_wdata` on the next clock edge. Every other control bit has no effect.
- R3: While `save_en` is 1, each bank byte takes the live counter byte on each clock edge, but only at its used bit positions. Bank indices, with the used-bit mask of each: 0 hundredths FF, 1 seconds 7F, 2 minutes 7F, 3 hours 9F (bit 7 is the PM flag), 4 day of month 3F, 5 month 1F, 6 year FF, 7 day of week 07, 8 day-of-year low FF, 9 day-of-year high 0F.
- R4: When a control write clears `save_en`, the bank holds the counter values sampled on that same edge. Later changes to the counters leave it unchanged.
- R5: Tracking does not change a bank bit outside a byte's used-bit mask. That bit keeps its previous value.
- R6: While `save_en` is 0, a host write stores all 8 bits of the addressed byte, and a read returns them.
- R7: While `save_en` is 1, a host write changes only the unused bit positions of the addressed byte. The used positions keep following the counter.
- R8: An increment pulse on `cnt_inc[j]` sets roll-over flag j on the next edge. The flag stays set until it is read. Flag j belongs to bank index j.
- R9: `stat_rdata` shows the flags. A cycle with `stat_re` high clears every flag on the next edge.
- R10: If an increment pulse for a flag arrives in the same cycle as a flag read, the set wins and the flag stays 1.
- R11: A read at an address at or above the number of bank bytes returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_flat | input | NUM_CNT*8 | Live counter bytes, index 0 in the low byte |
| cnt_inc | input | NUM_FLAG | One-cycle increment pulse for each flagged counter |
| ctrl_we | input | 1 | Write strobe for the control byte |
| ctrl_wdata | input | 8 | Control byte. Bit 7 is the save enable |
| save_en | output | 1 | Current save-enable state |
| bank_we | input | 1 | Bank write strobe |
| bank_addr | input | AW | Bank byte address |
| bank_wdata | input | 8 | Bank write data |
| bank_rdata | output | 8 | Bank read data for `bank_addr`, combinational |
| stat_re | input | 1 | Roll-over flag read strobe, which clears the flags |
| stat_rdata | output | NUM_FLAG | Roll-over flags |

## Verification
The bank is first loaded with a distinct pattern in RAM mode. Tracking is then switched on, so each byte read back shows whether the used positions took the counter value and whether the unused positions kept the RAM pattern. The counters change on the same cycle that the enable falls and change again afterwards, which shows whether the freeze took the edge-of-fall sample, a later sample or a stale one. The roll-over flags are driven by a lone pulse, then by a read alone, then by a read that coincides with a new pulse, which separates set, clear and the set-wins priority.

// File: rtl/tsb_pkg.sv
// Shared constants for the calendar snapshot bank.
// Assumes the counter byte order given in the brief (index 0 = hundredths).
package tsb_pkg;
    localparam int BYTE_W   = 8;
    localparam int SAVE_BIT = 7;

    // Used-bit mask of each counter byte; an unknown index is treated as fully used.
    function automatic logic [BYTE_W-1:0] used_mask(input int idx);
        case (idx)
            0:       return 8'hFF;
            1:       return 8'h7F;
            2:       return 8'h7F;
            3:       return 8'h9F;
            4:       return 8'h3F;
            5:       return 8'h1F;
            6:       return 8'hFF;
            7:       return 8'h07;
            8:       return 8'hFF;
            9:       return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/tsb_ctrl.sv
// Save-enable control register.
// Takes one bit of a control byte and ignores the rest; the bus decode lies outside.
module tsb_ctrl #(
    parameter int CTRL_W   = 8,
    parameter int SAVE_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic              save_en
);
    logic unused_ctrl_bits;
    assign unused_ctrl_bits = ^ctrl_wdata;

    // Load the save-enable bit on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)       save_en <= 1'b0;
        else if (ctrl_we) save_en <= ctrl_wdata[SAVE_BIT];
    end
endmodule

// File: rtl/tsb_cell.sv
// One byte of the snapshot bank.
// When tracking, the USED positions copy the live byte and the others stay
// open to host writes. When idle, the whole byte acts as RAM.
module tsb_cell #(
    parameter int             W    = 8,
    parameter logic [W-1:0]   USED = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         track,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] live,
    output logic [W-1:0] q
);
    logic [W-1:0] after_wr;
    logic [W-1:0] nxt;

    // Merge the host write; the counter-backed bits are protected while tracking.
    always_comb begin
        after_wr = q;
        if (wr) after_wr = track ? ((q & USED) | (wdata & ~USED)) : wdata;
    end

    // Overlay the live counter on the used positions while tracking.
    always_comb begin
        nxt = track ? ((after_wr & ~USED) | (live & USED)) : after_wr;
    end

    // Byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
endmodule

// File: rtl/tsb_rollflags.sv
// Sticky roll-over flags, cleared by a read.
// A set that arrives in the same cycle as a read wins.
module tsb_rollflags #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         rd,
    output logic [N-1:0] flags
);
    // Clear on read, then apply the new increments.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~{N{rd}}) | set;
    end
endmodule

// File: rtl/tsb_snapshot_bank.sv
// Calendar snapshot bank: a save-enable register, one tracking byte per
// counter, and clear-on-read roll-over flags.
// Assumes NUM_FLAG <= NUM_CNT and the counter byte order of tsb_pkg.
module tsb_snapshot_bank #(
    parameter int NUM_CNT  = 10,
    parameter int NUM_FLAG = 6,
    localparam int AW      = (NUM_CNT > 1) ? $clog2(NUM_CNT) + 1 : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CNT*8-1:0]    cnt_flat,
    input  logic [NUM_FLAG-1:0]     cnt_inc,
    input  logic                    ctrl_we,
    input  logic [7:0]              ctrl_wdata,
    output logic                    save_en,
    input  logic                    bank_we,
    input  logic [AW-1:0]           bank_addr,
    input  logic [7:0]              bank_wdata,
    output logic [7:0]              bank_rdata,
    input  logic                    stat_re,
    output logic [NUM_FLAG-1:0]     stat_rdata
);
    import tsb_pkg::*;

    logic [NUM_CNT*8-1:0] bank_flat;

    tsb_ctrl #(.CTRL_W(8), .SAVE_BIT(SAVE_BIT)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .save_en    (save_en)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cell
        localparam logic [7:0] USED_M = used_mask(g);
        logic sel;
        assign sel = bank_we && (bank_addr == AW'(g));
        tsb_cell #(.W(8), .USED(USED_M)) cell_i (
            .clk   (clk),
            .rst_n (rst_n),
            .track (save_en),
            .wr    (sel),
            .wdata (bank_wdata),
            .live  (cnt_flat[g*8 +: 8]),
            .q     (bank_flat[g*8 +: 8])
        );
    end

    // Read mux; addresses past the last byte return zero.
    always_comb begin
        bank_rdata = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (bank_addr == AW'(i)) bank_rdata = bank_flat[i*8 +: 8];
        end
    end

    tsb_rollflags #(.N(NUM_FLAG)) flags_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (cnt_inc),
        .rd    (stat_re),
        .flags (stat_rdata)
    );
endmodule

// File: rtl/tsb_snapshot_bank_chk.sv
// Temporal checks for tsb_snapshot_bank, attached with bind.
// Assumes reset is held for at least two cycles at start-up.
module tsb_snapshot_bank_chk #(
    parameter int NUM_CNT  = 10,
    parameter int NUM_FLAG = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_CNT*8-1:0] cnt_flat,
    input logic [NUM_CNT*8-1:0] bank_flat,
    input logic [NUM_FLAG-1:0]  cnt_inc,
    input logic                 ctrl_we,
    input logic [7:0]           ctrl_wdata,
    input logic                 save_en,
    input logic                 bank_we,
    input logic                 stat_re,
    input logic [NUM_FLAG-1:0]  stat_rdata
);
    logic [NUM_CNT*8-1:0] mask_all;
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_mask
        assign mask_all[g*8 +: 8] = tsb_pkg::used_mask(g);
    end

    // R2
    save_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> (save_en == $past(ctrl_wdata[7])));

    // R3
    track_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(save_en) |-> (((bank_flat ^ $past(cnt_flat)) & mask_all) == '0));

    // R4
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(save_en) && !$past(bank_we)) |-> $stable(bank_flat));

    // R5
    unused_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(save_en) && !$past(bank_we)) |->
            (((bank_flat ^ $past(bank_flat)) & ~mask_all) == '0));

    // R10
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((stat_rdata & $past(cnt_inc)) == $past(cnt_inc)));

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stat_re) |-> ((stat_rdata & ~$past(cnt_inc)) == '0));
endmodule

bind tsb_snapshot_bank tsb_snapshot_bank_chk #(.NUM_CNT(NUM_CNT), .NUM_FLAG(NUM_FLAG)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_flat   (cnt_flat),
    .bank_flat  (bank_flat),
    .cnt_inc    (cnt_inc),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .save_en    (save_en),
    .bank_we    (bank_we),
    .stat_re    (stat_re),
    .stat_rdata (stat_rdata)
);

// File: tb/tsb_snapshot_bank_tb.sv
// Directed bench for tsb_snapshot_bank: one task per scenario.
module tsb_snapshot_bank_tb_top;
    localparam int NC = 10;
    localparam int NF = 6;
    localparam int AW = $clog2(NC) + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NC*8-1:0]  cnt_flat;
    logic [NF-1:0]    cnt_inc = '0;
    logic             ctrl_we = 1'b0;
    logic [7:0]       ctrl_wdata = '0;
    logic             save_en;
    logic             bank_we = 1'b0;
    logic [AW-1:0]    bank_addr = '0;
    logic [7:0]       bank_wdata = '0;
    logic [7:0]       bank_rdata;
    logic             stat_re = 1'b0;
    logic [NF-1:0]    stat_rdata;

    logic [7:0] cnt_v [NC];
    logic [7:0] exp_b [NC];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NC; i++) cnt_flat[i*8 +: 8] = cnt_v[i];
    end

    tsb_snapshot_bank #(.NUM_CNT(NC), .NUM_FLAG(NF)) dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_flat(cnt_flat), .cnt_inc(cnt_inc),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .save_en(save_en),
        .bank_we(bank_we), .bank_addr(bank_addr), .bank_wdata(bank_wdata),
        .bank_rdata(bank_rdata), .stat_re(stat_re), .stat_rdata(stat_rdata)
    );

    // Used-bit masks as listed in the requirement R3.
    function automatic logic [7:0] req_mask(input int i);
        logic [7:0] t [10] = '{8'hFF, 8'h7F, 8'h7F, 8'h9F, 8'h3F,
                               8'h1F, 8'hFF, 8'h07, 8'hFF, 8'h0F};
        return t[i];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd_bank(input int a, output logic [7:0] d);
        @(negedge clk);
        bank_addr = AW'(a);
        #1 d = bank_rdata;
    endtask

    task automatic wr_bank(input int a, input logic [7:0] d);
        @(negedge clk);
        bank_we = 1'b1; bank_addr = AW'(a); bank_wdata = d;
        @(negedge clk);
        bank_we = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [7:0] d);
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_wdata = d;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic check_bank(input string tag);
        logic [7:0] d;
        for (int i = 0; i < NC; i++) begin
            rd_bank(i, d);
            chk($sformatf("%s byte%0d", tag, i), d, exp_b[i]);
        end
    endtask

    task automatic t_reset;
        chk("R1 save_en", save_en, 0);
        chk("R1 flags", stat_rdata, 0);
        for (int i = 0; i < NC; i++) exp_b[i] = 8'h00;
        check_bank("R1");
    endtask

    task automatic t_ram;
        logic [7:0] d;
        for (int i = 0; i < NC; i++) begin
            wr_bank(i, 8'hA0 + 8'(i));
            exp_b[i] = 8'hA0 + 8'(i);
        end
        check_bank("R6");
        wr_bank(12, 8'h5A);
        rd_bank(12, d);
        chk("R11 out-of-range", d, 0);
        check_bank("R6 after out-of-range write");
    endtask

    task automatic t_ctrl;
        wr_ctrl(8'h7F);
        chk("R2 bit7 clear", save_en, 0);
        check_bank("R2 no tracking");
    endtask

    task automatic t_track;
        for (int i = 0; i < NC; i++) cnt_v[i] = 8'h3C ^ 8'(i * 8'h11);
        wr_ctrl(8'h80);
        chk("R2 bit7 set", save_en, 1);
        for (int i = 0; i < NC; i++)
            exp_b[i] = (exp_b[i] & ~req_mask(i)) | (cnt_v[i] & req_mask(i));
        check_bank("R3 R5 track");
        for (int i = 0; i < NC; i++) cnt_v[i] = ~cnt_v[i];
        for (int i = 0; i < NC; i++)
            exp_b[i] = (exp_b[i] & ~req_mask(i)) | (cnt_v[i] & req_mask(i));
        check_bank("R3 follow");
    endtask

    task automatic t_locked_write;
        logic [7:0] d;
        wr_bank(7, 8'hFF);
        exp_b[7] = 8'hF8 | (cnt_v[7] & 8'h07);
        rd_bank(7, d);
        chk("R7 dow write", d, exp_b[7]);
        wr_bank(0, 8'h00);
        rd_bank(0, d);
        chk("R7 fully used byte", d, exp_b[0]);
    endtask

    task automatic t_freeze;
        @(negedge clk);
        for (int i = 0; i < NC; i++) cnt_v[i] = 8'(8'h91 + i * 3);
        ctrl_we = 1'b1; ctrl_wdata = 8'h00;
        @(negedge clk);
        ctrl_we = 1'b0;
        for (int i = 0; i < NC; i++) cnt_v[i] = 8'h00;
        chk("R4 save_en low", save_en, 0);
        for (int i = 0; i < NC; i++)
            exp_b[i] = (exp_b[i] & ~req_mask(i)) | (8'(8'h91 + i * 3) & req_mask(i));
        check_bank("R4 frozen");
        wr_bank(3, 8'h66);
        exp_b[3] = 8'h66;
        check_bank("R6 ram after freeze");
    endtask

    task automatic t_flags;
        @(negedge clk);
        cnt_inc = 6'b000010;
        @(negedge clk);
        cnt_inc = '0;
        chk("R8 set", stat_rdata, 6'b000010);
        @(negedge clk);
        chk("R8 sticky", stat_rdata, 6'b000010);
        stat_re = 1'b1;
        @(negedge clk);
        stat_re = 1'b0;
        chk("R9 cleared", stat_rdata, 0);
        cnt_inc = 6'b100100;
        @(negedge clk);
        cnt_inc = 6'b000101;
        stat_re = 1'b1;
        @(negedge clk);
        cnt_inc = '0;
        stat_re = 1'b0;
        chk("R10 set wins", stat_rdata, 6'b000101);
    endtask

    initial begin
        for (int i = 0; i < NC; i++) cnt_v[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ram();
        t_ctrl();
        t_track();
        t_locked_write();
        t_freeze();
        t_flags();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule